// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Aggregator

This block gathers a parameterised set of level-sensitive interrupt inputs, grouped in 32-bit words, and produces one parent interrupt line for each CPU. Every CPU owns a private mask bank. A source reaches a CPU only while its input is high and that CPU's mask bit for it is clear. The same source can therefore be enabled on one CPU and blocked on another.

Software reaches the banks through a 32-bit register port with a CPU-select input and a byte address. For a configuration of N words, each CPU's window holds four groups of N registers placed one after another:

| Word index | Group |
|---|---|
| 0 .. N-1 | raw input levels |
| N .. 2N-1 | current mask bits |
| 2N .. 3N-1 | mask-set port |
| 3N .. 4N-1 | mask-clear port |

Each register sits at byte address 4 times its word index. Reads return data in the same cycle. A write takes effect at the clock edge on which the write enable is sampled.

Top module: `irq_hub_top`

## Requirements
- R1: After reset every mask bit of every CPU is 1, every mask-status read returns 0xFFFFFFFF, and every parent line is 0.
- R2: Source n is bit n%32 of word n/32. A read at byte address 4*w returns the current input levels of word w, for any CPU.
- R3: A read at byte address 4*(N+w) returns the selected CPU's mask word w.
- R4: A write at byte address 4*(2N+w) sets to 1 each mask bit of word w whose data bit is 1. Bits written 0 keep their value.
- R5: A write at byte address 4*(3N+w) clears to 0 each mask bit of word w whose data bit is 1. Bits written 0 keep their value.
- R6: A CPU's parent line is high one clock after any source is high and unmasked for that CPU. It goes low one clock after no such source remains.
- R7: Mask writes change only the bank of the CPU given by the select input. Other CPUs' masks and parent lines are not affected.
- R8: Writes to raw-status or mask-status addresses change no mask bit, and the raw status cannot be cleared by any write.
- R9: Reads of mask-set and mask-clear addresses return 0. Addresses at or beyond byte 16*N read 0, and writes to them change no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcLevel | input | NUM_WORDS*32 | Level interrupt inputs; source n is bit n |
| cpuSel | input | CPU_W | Selects the CPU bank used for the access |
| regAddr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| wrEn | input | 1 | Write strobe, sampled at the clock edge |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the current address and CPU, combinational |
| parentIrq | output | NUM_CPUS | Registered interrupt line per CPU |

## Verification
A wrong mask bit can appear at the ports in two ways. It shows up at once on a mask-status read. If the matching input is high, it also shows up one clock later on that CPU's parent line. The bench walks every source on every CPU through unmask and mask. After each step it compares the mask read-back and both parent lines against a model, so a bit that lands in the wrong word, bit or CPU is seen within two cycles of the write. A full address sweep, before and after writes that should be ignored, exposes any decoder alias or any group offset that is off.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_RAW  = 2'd1,
    RD_MASK = 2'd2
  } rdSel_e;

  // Strobes passed from the decoder to the datapath.
  typedef struct packed {
    logic   setStb;
    logic   clrStb;
    rdSel_e rdSel;
    logic [2:0] wordIdx;
    logic [2:0] cpuIdx;
  } hubStrobe_t;

endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 6,
  parameter int CPU_W     = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CPU_W-1:0]  cpuSel,
  input  logic              wrEn,
  output hubStrobe_t        strobe
);

  localparam int RAW_END = NUM_WORDS;
  localparam int MSK_END = 2 * NUM_WORDS;
  localparam int SET_END = 3 * NUM_WORDS;
  localparam int CLR_END = 4 * NUM_WORDS;

  logic [31:0] idxW;
  logic        cpuOk;

  always_comb begin
    idxW  = 32'(regAddr[ADDR_W-1:2]);
    cpuOk = 32'(cpuSel) < 32'(NUM_CPUS);
    strobe         = '0;
    strobe.rdSel   = RD_ZERO;
    strobe.cpuIdx  = 3'(cpuSel);
    if (cpuOk) begin
      if (idxW < 32'(RAW_END)) begin
        strobe.rdSel   = RD_RAW;
        strobe.wordIdx = 3'(idxW);
      end else if (idxW < 32'(MSK_END)) begin
        strobe.rdSel   = RD_MASK;
        strobe.wordIdx = 3'(idxW - 32'(RAW_END));
      end else if (idxW < 32'(SET_END)) begin
        strobe.setStb  = wrEn;
        strobe.wordIdx = 3'(idxW - 32'(MSK_END));
      end else if (idxW < 32'(CLR_END)) begin
        strobe.clrStb  = wrEn;
        strobe.wordIdx = 3'(idxW - 32'(SET_END));
      end
    end
  end

  // R9: nothing beyond the four groups may produce a strobe or a read source
  assert_no_decode_past_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (32'(regAddr[ADDR_W-1:2]) >= 32'(CLR_END)) |->
      (!strobe.setStb && !strobe.clrStb && strobe.rdSel == RD_ZERO));

  // R8: a write strobe to the mask ports only arises from a bus write
  assert_strobe_needs_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setStb || strobe.clrStb) |-> wrEn);

endmodule

// File: rtl/irq_hub_datapath.sv
module irq_hub_datapath
  import irq_hub_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_WORDS*32-1:0]   srcLevel,
  input  logic [31:0]               wrData,
  input  hubStrobe_t                strobe,
  output logic [31:0]               rdData,
  output logic [NUM_CPUS-1:0]       parentIrq
);

  localparam int SRC_BITS = NUM_WORDS * 32;

  logic [31:0]         maskBank [NUM_CPUS][NUM_WORDS];
  logic [SRC_BITS-1:0] maskFlat [NUM_CPUS];
  logic                setHit   [NUM_CPUS][NUM_WORDS];
  logic                clrHit   [NUM_CPUS][NUM_WORDS];

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      assign setHit[c][w] = strobe.setStb && (strobe.cpuIdx == 3'(c)) && (strobe.wordIdx == 3'(w));
      assign clrHit[c][w] = strobe.clrStb && (strobe.cpuIdx == 3'(c)) && (strobe.wordIdx == 3'(w));
      assign maskFlat[c][w*32 +: 32] = maskBank[c][w];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             maskBank[c][w] <= '1;
        else if (setHit[c][w]) maskBank[c][w] <= maskBank[c][w] | wrData;
        else if (clrHit[c][w]) maskBank[c][w] <= maskBank[c][w] & ~wrData;
      end

      assert_set_masks_R4: assert property (@(posedge clk) disable iff (!rstN)
        setHit[c][w] |=> ((maskBank[c][w] & $past(wrData)) == $past(wrData)));

      assert_clr_unmasks_R5: assert property (@(posedge clk) disable iff (!rstN)
        clrHit[c][w] |=> ((maskBank[c][w] & $past(wrData)) == 32'h0));

      assert_mask_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
        !(setHit[c][w] || clrHit[c][w]) |=> $stable(maskBank[c][w]));
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) parentIrq[c] <= 1'b0;
      else       parentIrq[c] <= |(srcLevel & ~maskFlat[c]);
    end

    assert_parent_rise_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(parentIrq[c]) |-> $past(|(srcLevel & ~maskFlat[c])));
  end

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (strobe.cpuIdx == 3'(c) && strobe.wordIdx == 3'(w)) begin
          if (strobe.rdSel == RD_RAW)  rdData = srcLevel[w*32 +: 32];
          if (strobe.rdSel == RD_MASK) rdData = maskBank[c][w];
        end
      end
    end
  end

  // R9: addresses that decode to no readable group return zero
  assert_zero_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == RD_ZERO) |-> (rdData == 32'h0));

endmodule

// File: rtl/irq_hub_top.sv
module irq_hub_top
  import irq_hub_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int ADDR_W   = $clog2(NUM_WORDS * 16) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_WORDS*32-1:0] srcLevel,
  input  logic [CPU_W-1:0]        cpuSel,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic                    wrEn,
  input  logic [31:0]             wrData,
  output logic [31:0]             rdData,
  output logic [NUM_CPUS-1:0]     parentIrq
);

  hubStrobe_t strobe;

  irq_hub_ctrl #(
    .NUM_WORDS(NUM_WORDS), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W), .CPU_W(CPU_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .cpuSel(cpuSel),
    .wrEn(wrEn), .strobe(strobe)
  );

  irq_hub_datapath #(
    .NUM_WORDS(NUM_WORDS), .NUM_CPUS(NUM_CPUS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .wrData(wrData),
    .strobe(strobe), .rdData(rdData), .parentIrq(parentIrq)
  );

endmodule

// File: tb/tb_irq_hub_top.sv
module tb_irq_hub_top;
  localparam int NW = 2;
  localparam int NC = 2;
  localparam int AW = $clog2(NW * 16) + 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NW*32-1:0] srcLevel = '0;
  logic [0:0]      cpuSel = '0;
  logic [AW-1:0]   regAddr = '0;
  logic            wrEn = 1'b0;
  logic [31:0]     wrData = '0;
  logic [31:0]     rdData;
  logic [NC-1:0]   parentIrq;

  int checks = 0;
  int errors = 0;
  logic [31:0] expMask [NC][NW];

  always #4 clk = ~clk;

  irq_hub_top dut (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .cpuSel(cpuSel),
    .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .parentIrq(parentIrq)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(int cpu, int addr);
    int idx = addr >> 2;
    if (idx < NW)     return srcLevel[idx*32 +: 32];
    if (idx < 2 * NW) return expMask[cpu][idx - NW];
    return 32'h0;
  endfunction

  function automatic logic expParent(int cpu);
    logic [NW*32-1:0] m;
    for (int w = 0; w < NW; w++) m[w*32 +: 32] = expMask[cpu][w];
    return |(srcLevel & ~m);
  endfunction

  task automatic doWrite(int cpu, int addr, logic [31:0] d);
    int idx = addr >> 2;
    @(negedge clk);
    cpuSel = 1'(cpu); regAddr = AW'(addr); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    if (idx >= 2 * NW && idx < 3 * NW) expMask[cpu][idx - 2*NW] |= d;
    else if (idx >= 3 * NW && idx < 4 * NW) expMask[cpu][idx - 3*NW] &= ~d;
  endtask

  task automatic checkRead(string req, int cpu, int addr);
    cpuSel = 1'(cpu); regAddr = AW'(addr);
    #1;
    check(req, 64'(rdData), 64'(expRead(cpu, addr)));
  endtask

  task automatic checkParents(string req);
    @(negedge clk);
    for (int c = 0; c < NC; c++) check(req, 64'(parentIrq[c]), 64'(expParent(c)));
  endtask

  task automatic sweepAll(string req);
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < (1 << AW); a += 4) checkRead(req, c, a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) for (int w = 0; w < NW; w++) expMask[c][w] = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 parent", 64'(parentIrq), 64'(0));
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        cpuSel = 1'(c); regAddr = AW'(4 * (NW + w)); #1;
        check("R1 mask", 64'(rdData), 64'hFFFF_FFFF);
      end

    // R2 / R3: raw view under several patterns, all masked so no parent (R6)
    srcLevel = {32'hDEAD_BEEF, 32'h1234_5678}; sweepAll("R2 R3 sweep");
    srcLevel = {32'h0000_0001, 32'h8000_0000}; sweepAll("R2 R3 sweep");
    checkParents("R6 masked");

    // R4 R5 R6 R7: walk each source on each CPU
    for (int c = 0; c < NC; c++)
      for (int n = 0; n < NW * 32; n++) begin
        srcLevel = '0; srcLevel[n] = 1'b1;
        doWrite(c, 4 * (3*NW + n/32), 32'h1 << (n % 32));
        checkRead("R5 unmask", c, 4 * (NW + n/32));
        checkRead("R7 other bank", 1 - c, 4 * (NW + n/32));
        checkParents("R6 R7 parent rise");
        doWrite(c, 4 * (2*NW + n/32), 32'h1 << (n % 32));
        checkRead("R4 remask", c, 4 * (NW + n/32));
        checkParents("R6 parent fall");
      end

    // R4 R5: zero data bits leave mask bits alone
    doWrite(0, 4 * (3*NW), 32'h0000_FFFF);
    doWrite(0, 4 * (2*NW), 32'h0000_0F00);
    cpuSel = 1'b0; regAddr = AW'(4 * NW); #1;
    check("R4 R5 partial", 64'(rdData), 64'hFFFF_0F00);

    // R6: level follows the input; drop raw input then restore
    srcLevel = 64'h0000_0000_0000_0001;
    checkParents("R6 level high");
    check("R6 cpu0 high", 64'(parentIrq[0]), 64'(1));
    srcLevel = '0;
    checkParents("R6 level low");

    // R8: writes to raw and mask-status addresses ignored
    srcLevel = {32'hA5A5_0000, 32'h0000_00FF};
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < 8 * NW; a += 4) doWrite(c, a, 32'h0);
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < 8 * NW; a += 4) doWrite(c, a, 32'hFFFF_FFFF);
    sweepAll("R8 after status writes");
    checkParents("R8 parent");

    // R9: writes beyond the window ignored, reads of ports and beyond are zero
    for (int c = 0; c < NC; c++)
      for (int a = 16 * NW; a < (1 << AW); a += 4) begin
        doWrite(c, a, 32'hFFFF_FFFF);
        doWrite(c, a, 32'h0);
      end
    sweepAll("R9 sweep");
    checkParents("R9 parent");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule